// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is a single channel of a general-purpose timer. It watches a free-running counter that lives outside the block, and it works in one of three ways.

- **Input capture.** It waits for a chosen edge on its pin, then copies the counter into its 16-bit value register and raises its flag.
- **Output compare.** It raises its flag when the counter equals the value register. In the same cycle it drives its pin high or low, or toggles it.
- **PWM.** This is compare mode plus two extra controls. One toggles the pin on each counter overflow. The other forces a constant 0% or 100% output.

Software reaches the channel through a small byte-wide register bus with three addresses: control/status, value high byte and value low byte. The flag can only be cleared by a two-step sequence. Software first reads the control register while the flag is set, then writes a 0 to the flag bit. If a new event arrives between those two steps, the clear is cancelled, so no event is ever lost. The interrupt request follows the flag, gated by an enable bit.

Top module: `tmr_chan`

## Requirements
- R1: After reset, the control byte, both value bytes, `ch_pin_out` and `ch_irq` are all 0.
- R2: The control byte at address 0 has these bit positions: 7 flag, 6 irq enable, 5 mode B, 4 mode A, 3 edge select B, 2 edge select A, 1 toggle-on-overflow, 0 max duty. A write updates bits 6..0; writing 1 to bit 7 has no effect. Address 1 holds value bits 15..8 and address 2 holds bits 7..0; both read back what was written. When `HAS_MODE_B` is 0, bit 5 reads 0.
- R3: The mode is capture when mode A = 0 and the edge field {B,A} is non-zero. In that mode the field selects the edge: 01 rising, 10 falling, 11 either. A selected edge on `ch_pin_in` sets the flag on the third rising clock edge after the pin changes. Field 00 disables the channel.
- R4: When a capture event sets the flag, the counter value of that same cycle is written into the value register.
- R5: The mode is compare when mode A = 1 and the edge field is non-zero. In that mode, a cycle where `cnt_val` equals the value register sets the flag at the next clock edge.
- R6: On a compare match, the pin register responds to the edge field: 01 toggles it, 10 drives it to 0, 11 drives it to 1.
- R7: In compare mode, when toggle-on-overflow = 1 and max duty = 0, each `cnt_ovf` pulse toggles the pin register. If a match and an overflow fall in the same cycle, only the match action applies.
- R8: In compare mode with max duty = 1, the output is forced: field 10 drives `ch_pin_out` to 1 and field 11 drives it to 0. Overflow toggling is suppressed while max duty is set.
- R9: The flag clears when the control byte is read while the flag is set and a write with bit 7 = 0 follows.
- R10: A write with bit 7 = 0 that was not preceded by such a read leaves the flag set.
- R11: A capture or compare event arriving between the arming read and the clearing write cancels the clear; the flag stays set.
- R12: `ch_irq` is high exactly when the flag and the irq enable bit are both 1.
- R13: Outside compare mode, `ch_pin_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (arms the flag clear) |
| bus_addr | input | 2 | Register address: 0 control, 1 value high, 2 value low |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| cnt_val | input | 16 | Shared counter value |
| cnt_ovf | input | 1 | One-cycle counter overflow strobe |
| ch_pin_in | input | 1 | Channel pin input (asynchronous) |
| ch_pin_out | output | 1 | Channel pin drive |
| ch_irq | output | 1 | Interrupt request |

## Verification
The bench goes after the clearing interlock:
- a write of 0 with no arming read first, which a naive design would clear;
- an edge landing between the read and the write, which a design without the cancel would lose.

It checks capture latency and edge polarity, including an edge of the wrong direction. A design with a short synchronizer, or with swapped edge-select bits, would raise the flag at the wrong cycle or on the wrong edge.

Compare tests use random values and actions, with random overflow pulses mixed in. A same-cycle match and overflow catches a design that lets the toggle override the compare action. Forced duty is checked for both polarities and for suppressing the overflow toggle.

// File: rtl/tmr_ch_pkg.sv
package tmr_ch_pkg;

  localparam logic [1:0] ADDR_CTL = 2'd0;
  localparam logic [1:0] ADDR_HI  = 2'd1;
  localparam logic [1:0] ADDR_LO  = 2'd2;

  // control byte, bit 7 down to bit 0
  typedef struct packed {
    logic       flag;
    logic       ie;
    logic       msb;
    logic       msa;
    logic [1:0] els;
    logic       tov;
    logic       maxd;
  } ctl_t;

  function automatic logic mode_is_cmp(logic msa, logic [1:0] els);
    return msa & (|els);
  endfunction

  function automatic logic mode_is_cap(logic msa, logic [1:0] els);
    return ~msa & (|els);
  endfunction

  // which edges count: bit 0 enables rising, bit 1 enables falling
  function automatic logic edge_hit(logic rise, logic fall, logic [1:0] els);
    return (rise & els[0]) | (fall & els[1]);
  endfunction

  // pin level after a compare match
  function automatic logic match_level(logic cur, logic [1:0] els);
    case (els)
      2'b01:   return ~cur;
      2'b10:   return 1'b0;
      2'b11:   return 1'b1;
      default: return cur;
    endcase
  endfunction

endpackage

// File: rtl/tmr_ch_sync.sv
module tmr_ch_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  localparam int W = STAGES + 1;

  logic [W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[W-2:0], din};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
  assign fall = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/tmr_ch_flag.sv
module tmr_ch_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic rd_ctl,
  input  logic clr_wr,
  output logic flag,
  output logic armed
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else if (evt) begin
      flag  <= 1'b1;
      armed <= 1'b0;
    end else if (clr_wr && armed) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else if (rd_ctl && flag) begin
      armed <= 1'b1;
    end
  end
endmodule

// File: rtl/tmr_ch_outpin.sv
module tmr_ch_outpin
  import tmr_ch_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmp_mode,
  input  logic       match,
  input  logic       ovf,
  input  logic       tov,
  input  logic       maxd,
  input  logic [1:0] els,
  output logic       pin_q,
  output logic       pin_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else if (cmp_mode) begin
      if (match)                    pin_q <= match_level(pin_q, els);
      else if (ovf && tov && !maxd) pin_q <= ~pin_q;
    end
  end

  always_comb begin
    if (!cmp_mode)                  pin_out = 1'b0;
    else if (maxd && els == 2'b10)  pin_out = 1'b1;
    else if (maxd && els == 2'b11)  pin_out = 1'b0;
    else                            pin_out = pin_q;
  end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_ch_pkg::*;
#(
  parameter int CW          = 16,
  parameter int DW          = 8,
  parameter int AW          = 2,
  parameter int HAS_MODE_B  = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [CW-1:0] cnt_val,
  input  logic          cnt_ovf,
  input  logic          ch_pin_in,
  output logic          ch_pin_out,
  output logic          ch_irq
);
  localparam int HW = CW - DW;
  localparam logic MB_EN = (HAS_MODE_B != 0);

  logic          ie, msb, msa, tov, maxd;
  logic [1:0]    els;
  logic [CW-1:0] val_q;
  logic          flag_q, armed_q;
  logic          rise, fall;
  logic          cap_mode, cmp_mode;
  logic          cap_evt, match_evt, evt;
  logic          rd_ctl, wr_ctl, clr_wr;
  logic          pin_q;
  ctl_t          ctl_view;

  assign cap_mode  = mode_is_cap(msa, els);
  assign cmp_mode  = mode_is_cmp(msa, els);
  assign cap_evt   = cap_mode & edge_hit(rise, fall, els);
  assign match_evt = cmp_mode & (cnt_val == val_q);
  assign evt       = cap_evt | match_evt;

  assign rd_ctl = bus_rd & (bus_addr == AW'(ADDR_CTL));
  assign wr_ctl = bus_wr & (bus_addr == AW'(ADDR_CTL));
  assign clr_wr = wr_ctl & ~bus_wdata[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie <= 1'b0; msb <= 1'b0; msa <= 1'b0;
      els <= 2'b00; tov <= 1'b0; maxd <= 1'b0;
    end else if (wr_ctl) begin
      ie   <= bus_wdata[6];
      msb  <= MB_EN & bus_wdata[5];
      msa  <= bus_wdata[4];
      els  <= bus_wdata[3:2];
      tov  <= bus_wdata[1];
      maxd <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= '0;
    else if (cap_evt) val_q <= cnt_val;
    else if (bus_wr && bus_addr == AW'(ADDR_HI)) val_q[CW-1:DW] <= bus_wdata[HW-1:0];
    else if (bus_wr && bus_addr == AW'(ADDR_LO)) val_q[DW-1:0]  <= bus_wdata;
  end

  tmr_ch_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(ch_pin_in), .rise(rise), .fall(fall)
  );

  tmr_ch_flag u_flag (
    .clk(clk), .rst_n(rst_n), .evt(evt), .rd_ctl(rd_ctl), .clr_wr(clr_wr),
    .flag(flag_q), .armed(armed_q)
  );

  tmr_ch_outpin u_pin (
    .clk(clk), .rst_n(rst_n), .cmp_mode(cmp_mode), .match(match_evt),
    .ovf(cnt_ovf), .tov(tov), .maxd(maxd), .els(els),
    .pin_q(pin_q), .pin_out(ch_pin_out)
  );

  assign ctl_view = '{flag: flag_q, ie: ie, msb: msb, msa: msa,
                      els: els, tov: tov, maxd: maxd};

  always_comb begin
    case (bus_addr)
      AW'(ADDR_CTL): bus_rdata = ctl_view;
      AW'(ADDR_HI):  bus_rdata = DW'(val_q[CW-1:DW]);
      AW'(ADDR_LO):  bus_rdata = val_q[DW-1:0];
      default:       bus_rdata = '0;
    endcase
  end

  assign ch_irq = flag_q & ie;
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] cnt_val,
  input logic [CW-1:0] val_q,
  input logic          flag_q,
  input logic          armed_q,
  input logic          evt,
  input logic          clr_wr,
  input logic          cap_evt,
  input logic          match_evt,
  input logic [1:0]    els,
  input logic          pin_q
);
  p_match_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> flag_q);

  p_cap_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (val_q == $past(cnt_val)));

  p_event_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && clr_wr) |=> flag_q);

  p_clear_needs_arm_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !armed_q) |=> flag_q);

  p_set_action_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && els == 2'b11) |=> pin_q);

  p_clr_action_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && els == 2'b10) |=> !pin_q);
endmodule

bind tmr_chan tmr_chan_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .val_q(val_q),
  .flag_q(flag_q), .armed_q(armed_q), .evt(evt), .clr_wr(clr_wr),
  .cap_evt(cap_evt), .match_evt(match_evt), .els(els), .pin_q(pin_q)
);

// File: tb/tmr_chan_bench.sv
module tmr_chan_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [7:0]  bus_wdata = 8'd0;
  logic [7:0]  bus_rdata;
  logic [15:0] cnt_val = 16'h0;
  logic        cnt_ovf = 1'b0;
  logic        ch_pin_in = 1'b0;
  logic        ch_pin_out, ch_irq;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic exp_pin = 1'b0;
  logic [7:0] rb;

  always #10 clk = ~clk;

  tmr_chan u_tmr_chan (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt_val(cnt_val), .cnt_ovf(cnt_ovf), .ch_pin_in(ch_pin_in),
    .ch_pin_out(ch_pin_out), .ch_irq(ch_irq)
  );

  function automatic logic after_match(logic cur, logic [1:0] act);
    if (act == 2'd1) return !cur;
    if (act == 2'd2) return 1'b0;
    if (act == 2'd3) return 1'b1;
    return cur;
  endfunction

  function automatic logic [7:0] cmp_ctl(logic [1:0] act, logic tv, logic mx);
    return 8'h40 + 8'h10 + {4'd0, act, 2'd0} + {6'd0, tv, mx};
  endfunction

  task automatic chk(string tag, logic [15:0] got, logic [15:0] expv);
    n_chk++;
    if (got !== expv) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, expv);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // one compare match against value v, optionally overlapping an overflow
  task automatic do_match(logic [15:0] v, logic [7:0] ctl, logic with_ovf);
    logic [7:0] junk;
    cnt_val = ~v;
    wr(2'd0, ctl);
    wr(2'd1, v[15:8]);
    wr(2'd2, v[7:0]);
    cnt_val = v; cnt_ovf = with_ovf;
    @(negedge clk);
    cnt_val = v + 16'd1; cnt_ovf = 1'b0;
    exp_pin = after_match(exp_pin, ctl[3:2]);
    chk("R5 flag after match", {15'd0, ch_irq}, 16'd1);
    chk("R6/R7 pin after match", {15'd0, ch_pin_out}, {15'd0, exp_pin});
    rd(2'd0, junk);
    wr(2'd0, ctl);
    chk("R9 cleared", {15'd0, ch_irq}, 16'd0);
  endtask

  initial begin
    void'($urandom(32'd1357));
    tick(2);
    rst_n = 1'b1;
    tick(1);
    // R1
    rd(2'd0, rb); chk("R1 ctl", {8'd0, rb}, 16'h00);
    rd(2'd1, rb); chk("R1 hi", {8'd0, rb}, 16'h00);
    rd(2'd2, rb); chk("R1 lo", {8'd0, rb}, 16'h00);
    chk("R1 pin/irq", {14'd0, ch_pin_out, ch_irq}, 16'd0);

    // R2: register layout and readback
    cnt_val = 16'h0000;
    wr(2'd1, 8'hA5); wr(2'd2, 8'h3C);
    wr(2'd0, 8'hFC);
    rd(2'd0, rb); chk("R2 ctl bit7 ignored", {8'd0, rb}, 16'h007C);
    rd(2'd1, rb); chk("R2 hi", {8'd0, rb}, 16'h00A5);
    rd(2'd2, rb); chk("R2 lo", {8'd0, rb}, 16'h003C);
    wr(2'd0, 8'h00);

    // R3/R4/R13 rising capture
    cnt_val = 16'h1234;
    wr(2'd0, 8'h44);
    ch_pin_in = 1'b1;
    tick(2); chk("R3 latency not yet", {15'd0, ch_irq}, 16'd0);
    tick(1); chk("R3 rising capture", {15'd0, ch_irq}, 16'd1);
    chk("R13 pin idle in capture", {15'd0, ch_pin_out}, 16'd0);
    rd(2'd1, rb); chk("R4 captured hi", {8'd0, rb}, 16'h0012);
    rd(2'd2, rb); chk("R4 captured lo", {8'd0, rb}, 16'h0034);
    // R10 (the reads above were of value bytes, not the control byte)
    wr(2'd0, 8'h44);
    chk("R10 unarmed write 0", {15'd0, ch_irq}, 16'd1);
    rd(2'd0, rb); chk("R2 flag visible", {8'd0, rb}, 16'h00C4);
    wr(2'd0, 8'h44);
    chk("R9 read then write 0", {15'd0, ch_irq}, 16'd0);
    ch_pin_in = 1'b0; tick(4);
    chk("R3 falling ignored in rising mode", {15'd0, ch_irq}, 16'd0);

    // falling mode
    cnt_val = 16'h0ABC;
    wr(2'd0, 8'h48);
    ch_pin_in = 1'b1; tick(4);
    chk("R3 rising ignored in falling mode", {15'd0, ch_irq}, 16'd0);
    ch_pin_in = 1'b0; tick(3);
    chk("R3 falling capture", {15'd0, ch_irq}, 16'd1);
    rd(2'd2, rb); chk("R4 falling captured lo", {8'd0, rb}, 16'h00BC);

    // R11: event between arming read and clearing write
    wr(2'd0, 8'h4C);
    rd(2'd0, rb);
    ch_pin_in = 1'b1; tick(3);
    wr(2'd0, 8'h4C);
    chk("R11 new edge cancels clear", {15'd0, ch_irq}, 16'd1);
    rd(2'd0, rb); wr(2'd0, 8'h4C);
    chk("R9 clear after rearm", {15'd0, ch_irq}, 16'd0);

    // edge field 00: no capture
    wr(2'd0, 8'h40);
    ch_pin_in = 1'b0; tick(4); ch_pin_in = 1'b1; tick(4);
    chk("R3 field 00 disabled", {15'd0, ch_irq}, 16'd0);

    // compare: directed actions
    do_match(16'h2040, cmp_ctl(2'd3, 1'b0, 1'b0), 1'b0);
    do_match(16'h0301, cmp_ctl(2'd2, 1'b0, 1'b0), 1'b0);
    do_match(16'hFFFE, cmp_ctl(2'd1, 1'b0, 1'b0), 1'b0);
    // R7: same-cycle match and overflow, the set action wins
    do_match(16'h1111, cmp_ctl(2'd3, 1'b1, 1'b0), 1'b1);

    // R12: flag without enable
    cnt_val = 16'h5000;
    wr(2'd0, 8'h1C); wr(2'd1, 8'h50); wr(2'd2, 8'h00);
    tick(1); cnt_val = 16'h5001;
    chk("R12 irq masked", {15'd0, ch_irq}, 16'd0);
    exp_pin = 1'b1;
    wr(2'd0, 8'h5C);
    chk("R12 irq after enable", {15'd0, ch_irq}, 16'd1);
    rd(2'd0, rb); wr(2'd0, 8'h5C);

    // R8: forced duty
    wr(2'd0, cmp_ctl(2'd2, 1'b1, 1'b1));
    chk("R8 100% duty", {15'd0, ch_pin_out}, 16'd1);
    cnt_ovf = 1'b1; tick(1); cnt_ovf = 1'b0;
    wr(2'd0, cmp_ctl(2'd3, 1'b1, 1'b1));
    chk("R8 0% duty", {15'd0, ch_pin_out}, 16'd0);
    wr(2'd0, cmp_ctl(2'd3, 1'b1, 1'b0));
    chk("R8 overflow suppressed under max", {15'd0, ch_pin_out}, {15'd0, exp_pin});

    // random compare and overflow mix
    for (int i = 0; i < 30; i++) begin
      logic [1:0] act = 2'(1 + ($urandom % 3));
      logic tv = 1'($urandom % 2);
      logic [15:0] v = 16'($urandom);
      do_match(v, cmp_ctl(act, tv, 1'b0), 1'b0);
      if ($urandom % 2 == 0) begin
        cnt_ovf = 1'b1; tick(1); cnt_ovf = 1'b0;
        if (tv) exp_pin = !exp_pin;
        chk("R7 overflow toggle", {15'd0, ch_pin_out}, {15'd0, exp_pin});
      end
    end

    // R13 pin idle after leaving compare mode
    wr(2'd0, 8'h44);
    chk("R13 pin idle in capture", {15'd0, ch_pin_out}, 16'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule